// File: doc/BRIEF.md
# Keyboard Controller Host Mailbox

This block sits between a host processor and a small keyboard microcontroller and carries single bytes in both directions. The host sees a data location, which accepts command bytes and returns reply bytes, and a separate status location holding two full flags. The microcontroller sees a receive strobe, a send strobe and an 8-bit input port. One bit of that port carries the reply-buffer state as an active-low flag.

Each direction has a one-byte holding register and a full flag. A host byte raises an interrupt towards the microcontroller until the microcontroller takes it. A microcontroller byte raises the host keyboard interrupt until the host reads it. The block also turns two output-port bits of the microcontroller into the keyboard clock and data lines. It folds the returning keyboard data line and one system-control bit back into the input port. The host can also read without side effects (a peek), which debug accesses use.

Top module: `kbd_mailbox`

## Requirements
- R1: A host write strobe at the data address (0x60) latches `host_wdata`. From the next cycle the command-full flag is set, `mcu_int` is high and `mcu_rdata` shows the byte.
- R2: While `mcu_rd` is high, `mcu_rdata` shows the latched command byte. From the next cycle the command-full flag is clear and `mcu_int` is low.
- R3: A `mcu_wr` strobe latches `mcu_wdata`. From the next cycle bit 6 of `mcu_pin` is 0 (reply full, active low) and `host_irq` is high.
- R4: A host read strobe at the data address shows the reply byte on `host_rdata` during the strobe. From the next cycle bit 6 of `mcu_pin` is 1 and `host_irq` is low.
- R5: A peek (`host_peek`) returns the same data as a read but changes no flag, no byte and no interrupt.
- R6: A read or peek of the status address (0x64) returns bit 1 = command full and bit 0 = reply full, with bits 7..2 zero. A write to the status address has no effect. An access to any other address returns 0xFF.
- R7: A `mcu_pout_wr` strobe stores the inverse of `mcu_pout[1:0]`. From the next cycle `kbd_clk_o` equals the inverse of bit 0 and `kbd_data_o` the inverse of bit 1, and `mcu_pin[1:0]` carries the same two inverted bits.
- R8: `kbd_data_i` is sampled by one register stage. While the sampled value is low, `mcu_pin[1]` reads 0.
- R9: `mcu_pin[2]` follows `sys_mirror_i` in the same cycle. `mcu_pin` bits 7, 5, 4 and 3 are always zero.
- R10: After reset `mcu_pin` is 0x40 (with `sys_mirror_i` low), both buffers are empty, `host_irq` and `mcu_int` are low, both keyboard outputs are low, and the sampled keyboard data is high.
- R11: When a fill and a drain of the same buffer fall in the same cycle, the fill wins: the new byte is stored and the buffer stays full.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| host_addr | input | 8 | Host I/O address |
| host_wr | input | 1 | Host write strobe, one cycle |
| host_rd | input | 1 | Host read strobe with side effects |
| host_peek | input | 1 | Host read without side effects |
| host_wdata | input | 8 | Host write data |
| host_rdata | output | 8 | Host read data, valid while a read or peek is active |
| host_irq | output | 1 | Host keyboard interrupt, high while the reply buffer is full |
| mcu_rd | input | 1 | Microcontroller receive strobe |
| mcu_rdata | output | 8 | Latched command byte |
| mcu_wr | input | 1 | Microcontroller send strobe |
| mcu_wdata | input | 8 | Reply byte |
| mcu_int | output | 1 | Microcontroller input interrupt, high while the command buffer is full |
| mcu_pin | output | 8 | Microcontroller input port value |
| mcu_pout_wr | input | 1 | Output-port write strobe |
| mcu_pout | input | 8 | Output-port write data |
| kbd_clk_o | output | 1 | Keyboard clock drive |
| kbd_data_o | output | 1 | Keyboard data drive |
| kbd_data_i | input | 1 | Keyboard data line from the keyboard |
| sys_mirror_i | input | 1 | System control bit folded into input-port bit 2 |

## Verification
The assertions assume single-cycle strobes that are only meaningful after reset has been released. They also assume that a peek is never raised together with a read strobe. The bench drives every strobe for exactly one clock. It never mixes a peek with a read, and it overlaps a fill with a drain only in the deliberate collision cases for R11. The keyboard data line and the mirror input change only between edges.

// File: rtl/kbm_pkg.sv
// Shared constants for the keyboard mailbox.
// Assumes: 8-bit host and controller data paths.
package kbm_pkg;
    localparam int BYTE_W       = 8;
    localparam int PIN_OBF_N    = 6;  // input-port bit: reply full, active low
    localparam int PIN_MIRROR   = 2;  // input-port bit: system mirror
    localparam int STAT_IBF     = 1;  // status bit: command full
    localparam int STAT_OBF     = 0;  // status bit: reply full
    localparam logic [BYTE_W-1:0] UNMAPPED = '1;

    // Builds the host status byte from the two flags.
    function automatic logic [BYTE_W-1:0] status_byte(input logic ibf, input logic obf);
        logic [BYTE_W-1:0] s;
        s = '0;
        s[STAT_IBF] = ibf;
        s[STAT_OBF] = obf;
        return s;
    endfunction
endpackage

// File: rtl/kbm_host_decode.sv
// Host address decode: turns raw host strobes into data-port actions and
// read-path selects.
// Assumes: host_peek and host_rd are not raised in the same cycle.
module kbm_host_decode #(
    parameter int          ADDR_W    = 8,
    parameter logic [7:0]  DATA_ADDR = 8'h60,
    parameter logic [7:0]  STAT_ADDR = 8'h64
) (
    input  logic [ADDR_W-1:0] addr,
    input  logic              wr,
    input  logic              rd,
    input  logic              peek,
    output logic              data_wr,
    output logic              data_rd,
    output logic              sel_data,
    output logic              sel_stat,
    output logic              any_read
);
    logic hit_data, hit_stat;

    // Address compare and strobe qualification.
    always_comb begin
        hit_data = (addr == ADDR_W'(DATA_ADDR));
        hit_stat = (addr == ADDR_W'(STAT_ADDR));
        data_wr  = wr & hit_data;
        data_rd  = rd & hit_data;
        any_read = rd | peek;
        sel_data = hit_data;
        sel_stat = hit_stat;
    end
endmodule

// File: rtl/kbm_byte_buf.sv
// One-byte holding register with a full flag. A fill and a drain in the
// same cycle keep the buffer full with the new byte.
// Assumes: fill and drain are single-cycle strobes.
module kbm_byte_buf #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         fill,
    input  logic [W-1:0] fill_data,
    input  logic         drain,
    output logic [W-1:0] held,
    output logic         full
);
    // Latch the byte on a fill.
    always_ff @(posedge clk) begin
        if (!rst_n)     held <= '0;
        else if (fill)  held <= fill_data;
    end

    // Full flag: a fill sets it and takes priority over a drain.
    always_ff @(posedge clk) begin
        if (!rst_n)      full <= 1'b0;
        else if (fill)   full <= 1'b1;
        else if (drain)  full <= 1'b0;
    end

    a_r11_fill_wins: assert property (@(posedge clk) disable iff (!rst_n)
        (fill && drain) |=> (full && held == $past(fill_data)));
    a_r2_drain_clears: assert property (@(posedge clk) disable iff (!rst_n)
        (drain && !fill) |=> !full);
    a_r1_fill_sets: assert property (@(posedge clk) disable iff (!rst_n)
        fill |=> (full && held == $past(fill_data)));
    a_r5_idle_holds: assert property (@(posedge clk) disable iff (!rst_n)
        (!fill && !drain) |=> ($stable(full) && $stable(held)));
endmodule

// File: rtl/kbm_port.sv
// Controller port logic: stores the inverted output-port bits that drive
// the keyboard lines, samples the returning keyboard data and assembles
// the controller input port.
// Assumes: kbd_data_i is already synchronous to clk.
module kbm_port #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         pout_wr,
    input  logic [W-1:0] pout,
    input  logic         kbd_data_i,
    input  logic         sys_mirror,
    input  logic         reply_full,
    output logic [W-1:0] pin,
    output logic         kbd_clk_o,
    output logic         kbd_data_o
);
    import kbm_pkg::*;
    logic [1:0] line_q;
    logic       kbd_q;

    // Store the inverted low output-port bits.
    always_ff @(posedge clk) begin
        if (!rst_n)        line_q <= 2'b00;
        else if (pout_wr)  line_q <= ~pout[1:0];
    end

    // Sample the keyboard data line; reset takes it as high.
    always_ff @(posedge clk) begin
        if (!rst_n) kbd_q <= 1'b1;
        else        kbd_q <= kbd_data_i;
    end

    // Assemble the input port value.
    always_comb begin
        pin             = '0;
        pin[0]          = line_q[0];
        pin[1]          = line_q[1] & kbd_q;
        pin[PIN_MIRROR] = sys_mirror;
        pin[PIN_OBF_N]  = ~reply_full;
        kbd_clk_o       = line_q[0];
        kbd_data_o      = line_q[1];
    end

    a_r7_lines_follow: assert property (@(posedge clk) disable iff (!rst_n)
        pout_wr |=> (kbd_clk_o == !$past(pout[0]) && kbd_data_o == !$past(pout[1])
                     && pin[0] == !$past(pout[0])));
    a_r8_data_low_forces: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && !$past(kbd_data_i)) |-> !pin[1]);
endmodule

// File: rtl/kbd_mailbox.sv
// Keyboard controller host mailbox top: host decode, two byte buffers and
// the controller port logic.
// Assumes: single-cycle strobes on both sides; peek never with read.
module kbd_mailbox #(
    parameter int          ADDR_W    = 8,
    parameter logic [7:0]  DATA_ADDR = 8'h60,
    parameter logic [7:0]  STAT_ADDR = 8'h64
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] host_addr,
    input  logic              host_wr,
    input  logic              host_rd,
    input  logic              host_peek,
    input  logic [7:0]        host_wdata,
    output logic [7:0]        host_rdata,
    output logic              host_irq,
    input  logic              mcu_rd,
    output logic [7:0]        mcu_rdata,
    input  logic              mcu_wr,
    input  logic [7:0]        mcu_wdata,
    output logic              mcu_int,
    output logic [7:0]        mcu_pin,
    input  logic              mcu_pout_wr,
    input  logic [7:0]        mcu_pout,
    output logic              kbd_clk_o,
    output logic              kbd_data_o,
    input  logic              kbd_data_i,
    input  logic              sys_mirror_i
);
    import kbm_pkg::*;
    logic       data_wr, data_rd, sel_data, sel_stat, any_read;
    logic [7:0] cmd_byte, rep_byte;
    logic       cmd_full, rep_full;

    kbm_host_decode #(.ADDR_W(ADDR_W), .DATA_ADDR(DATA_ADDR), .STAT_ADDR(STAT_ADDR)) dec_i (
        .addr(host_addr), .wr(host_wr), .rd(host_rd), .peek(host_peek),
        .data_wr(data_wr), .data_rd(data_rd), .sel_data(sel_data),
        .sel_stat(sel_stat), .any_read(any_read));

    kbm_byte_buf #(.W(BYTE_W)) cmd_i (
        .clk(clk), .rst_n(rst_n), .fill(data_wr), .fill_data(host_wdata),
        .drain(mcu_rd), .held(cmd_byte), .full(cmd_full));

    kbm_byte_buf #(.W(BYTE_W)) rep_i (
        .clk(clk), .rst_n(rst_n), .fill(mcu_wr), .fill_data(mcu_wdata),
        .drain(data_rd), .held(rep_byte), .full(rep_full));

    kbm_port #(.W(BYTE_W)) port_i (
        .clk(clk), .rst_n(rst_n), .pout_wr(mcu_pout_wr), .pout(mcu_pout),
        .kbd_data_i(kbd_data_i), .sys_mirror(sys_mirror_i), .reply_full(rep_full),
        .pin(mcu_pin), .kbd_clk_o(kbd_clk_o), .kbd_data_o(kbd_data_o));

    // Host read mux and interrupt outputs.
    always_comb begin
        if (!any_read)     host_rdata = UNMAPPED;
        else if (sel_data) host_rdata = rep_byte;
        else if (sel_stat) host_rdata = status_byte(cmd_full, rep_full);
        else               host_rdata = UNMAPPED;
        host_irq  = rep_full;
        mcu_int   = cmd_full;
        mcu_rdata = cmd_byte;
    end

    a_r3_reply_posted: assert property (@(posedge clk) disable iff (!rst_n)
        mcu_wr |=> (host_irq && !mcu_pin[6]));
    a_r4_reply_taken: assert property (@(posedge clk) disable iff (!rst_n)
        (host_rd && host_addr == ADDR_W'(DATA_ADDR) && !mcu_wr) |=> (!host_irq && mcu_pin[6]));
    a_r1_cmd_posted: assert property (@(posedge clk) disable iff (!rst_n)
        (host_wr && host_addr == ADDR_W'(DATA_ADDR)) |=> mcu_int);
    a_r5_peek_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        (host_peek && !host_wr && !mcu_wr && !mcu_rd) |=> ($stable(host_irq) && $stable(mcu_int)));
    a_r6_status_write_void: assert property (@(posedge clk) disable iff (!rst_n)
        (host_wr && host_addr == ADDR_W'(STAT_ADDR) && !mcu_rd) |=> $stable(mcu_int));
endmodule

// File: tb/kbd_mailbox_tb_top.sv
// Scoreboard bench for the keyboard mailbox.
module kbd_mailbox_tb_top;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [7:0] host_addr = 8'h00;
    logic       host_wr = 0, host_rd = 0, host_peek = 0;
    logic [7:0] host_wdata = 0;
    logic [7:0] host_rdata;
    logic       host_irq;
    logic       mcu_rd = 0, mcu_wr = 0;
    logic [7:0] mcu_rdata;
    logic [7:0] mcu_wdata = 0;
    logic       mcu_int;
    logic [7:0] mcu_pin;
    logic       mcu_pout_wr = 0;
    logic [7:0] mcu_pout = 0;
    logic       kbd_clk_o, kbd_data_o;
    logic       kbd_data_i = 1'b1;
    logic       sys_mirror_i = 1'b0;

    int checks = 0;
    int errors = 0;
    logic [7:0] to_host_q[$];
    logic [7:0] to_mcu_q[$];

    always #4 clk = ~clk;

    kbd_mailbox dut_i (
        .clk(clk), .rst_n(rst_n), .host_addr(host_addr), .host_wr(host_wr),
        .host_rd(host_rd), .host_peek(host_peek), .host_wdata(host_wdata),
        .host_rdata(host_rdata), .host_irq(host_irq), .mcu_rd(mcu_rd),
        .mcu_rdata(mcu_rdata), .mcu_wr(mcu_wr), .mcu_wdata(mcu_wdata),
        .mcu_int(mcu_int), .mcu_pin(mcu_pin), .mcu_pout_wr(mcu_pout_wr),
        .mcu_pout(mcu_pout), .kbd_clk_o(kbd_clk_o), .kbd_data_o(kbd_data_o),
        .kbd_data_i(kbd_data_i), .sys_mirror_i(sys_mirror_i));

    task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%02h expected=%02h", req, act, exp);
        end
    endtask

    // Monitor: pops expected bytes whenever a consuming read is on the bus.
    always @(negedge clk) begin
        if (rst_n && host_rd && host_addr == 8'h60) begin
            checks++;
            if (to_host_q.size() == 0) begin
                errors++; $display("FAIL R4 actual=%02h expected=none", host_rdata);
            end else begin
                logic [7:0] e;
                e = to_host_q.pop_front();
                if (host_rdata !== e) begin
                    errors++; $display("FAIL R4 actual=%02h expected=%02h", host_rdata, e);
                end
            end
        end
        if (rst_n && mcu_rd) begin
            checks++;
            if (to_mcu_q.size() == 0) begin
                errors++; $display("FAIL R2 actual=%02h expected=none", mcu_rdata);
            end else begin
                logic [7:0] e;
                e = to_mcu_q.pop_front();
                if (mcu_rdata !== e) begin
                    errors++; $display("FAIL R2 actual=%02h expected=%02h", mcu_rdata, e);
                end
            end
        end
    end

    task automatic strobe_end;
        @(posedge clk); #1;
        host_wr = 0; host_rd = 0; host_peek = 0; mcu_rd = 0; mcu_wr = 0; mcu_pout_wr = 0;
    endtask

    task automatic host_write(input logic [7:0] a, input logic [7:0] d);
        @(posedge clk); #1;
        host_addr = a; host_wdata = d; host_wr = 1;
        if (a == 8'h60) to_mcu_q.push_back(d);
        strobe_end();
    endtask

    task automatic host_read_data;
        @(posedge clk); #1;
        host_addr = 8'h60; host_rd = 1;
        strobe_end();
    endtask

    task automatic mcu_read;
        @(posedge clk); #1; mcu_rd = 1;
        strobe_end();
    endtask

    task automatic mcu_write(input logic [7:0] d);
        @(posedge clk); #1; mcu_wdata = d; mcu_wr = 1;
        to_host_q.push_back(d);
        strobe_end();
    endtask

    task automatic peek(input logic [7:0] a, output logic [7:0] v);
        @(posedge clk); #1; host_addr = a; host_peek = 1;
        @(negedge clk); v = host_rdata;
        strobe_end();
    endtask

    task automatic pout_write(input logic [7:0] d);
        @(posedge clk); #1; mcu_pout = d; mcu_pout_wr = 1;
        strobe_end();
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        errors++;
        $display("FAIL watchdog actual=running expected=finished");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        logic [7:0] v;
        repeat (3) @(posedge clk);
        #1 rst_n = 1;
        @(negedge clk);
        // R10 reset state
        chk("R10 pin", mcu_pin, 8'h40);
        chk("R10 irq/int", {6'b0, host_irq, mcu_int}, 8'h00);
        chk("R10 kbd lines", {6'b0, kbd_clk_o, kbd_data_o}, 8'h00);
        peek(8'h64, v); chk("R10 status", v, 8'h00);

        // R1 host command
        host_write(8'h60, 8'h5A);
        @(negedge clk);
        chk("R1 mcu_int", {7'b0, mcu_int}, 8'h01);
        chk("R1 mcu_rdata", mcu_rdata, 8'h5A);
        peek(8'h64, v); chk("R6 status ibf", v, 8'h02);

        // R2 controller takes it
        mcu_read();
        @(negedge clk);
        chk("R2 mcu_int", {7'b0, mcu_int}, 8'h00);
        peek(8'h64, v); chk("R2 status", v, 8'h00);

        // R3 controller reply
        mcu_write(8'hC3);
        @(negedge clk);
        chk("R3 pin", mcu_pin, 8'h00);
        chk("R3 host_irq", {7'b0, host_irq}, 8'h01);
        peek(8'h64, v); chk("R6 status obf", v, 8'h01);

        // R5 peek leaves state
        peek(8'h60, v); chk("R5 peek data", v, 8'hC3);
        @(negedge clk);
        chk("R5 irq kept", {7'b0, host_irq}, 8'h01);
        chk("R5 pin kept", mcu_pin, 8'h00);

        // R4 host read drains
        host_read_data();
        @(negedge clk);
        chk("R4 pin", mcu_pin, 8'h40);
        chk("R4 host_irq", {7'b0, host_irq}, 8'h00);

        // R6 status write ignored, unmapped reads 0xFF
        host_write(8'h64, 8'h77);
        @(negedge clk);
        chk("R6 mcu_int after status write", {7'b0, mcu_int}, 8'h00);
        peek(8'h64, v); chk("R6 status after write", v, 8'h00);
        peek(8'h61, v); chk("R6 unmapped", v, 8'hFF);

        // R7 output port to keyboard lines
        pout_write(8'h01);
        @(negedge clk);
        chk("R7 lines 01", {6'b0, kbd_data_o, kbd_clk_o}, 8'h02);
        chk("R7 pin 01", mcu_pin, 8'h42);
        pout_write(8'h02);
        @(negedge clk);
        chk("R7 lines 02", {6'b0, kbd_data_o, kbd_clk_o}, 8'h01);
        chk("R7 pin 02", mcu_pin, 8'h41);

        // R8 keyboard data low forces pin bit 1
        pout_write(8'h00);
        @(posedge clk); #1 kbd_data_i = 1'b0;
        @(posedge clk); @(negedge clk);
        chk("R8 pin data low", mcu_pin, 8'h41);
        chk("R8 drive kept", {7'b0, kbd_data_o}, 8'h01);
        @(posedge clk); #1 kbd_data_i = 1'b1;
        @(posedge clk); @(negedge clk);
        chk("R8 pin data high", mcu_pin, 8'h43);

        // R9 mirror bit
        #1 sys_mirror_i = 1'b1;
        @(negedge clk);
        chk("R9 pin mirror", mcu_pin, 8'h47);
        #1 sys_mirror_i = 1'b0;

        // R11 command collision: fill beats drain
        host_write(8'h60, 8'h11);
        @(posedge clk); #1;
        host_addr = 8'h60; host_wdata = 8'h22; host_wr = 1; mcu_rd = 1;
        to_mcu_q.push_back(8'h22);
        strobe_end();
        @(negedge clk);
        chk("R11 cmd full", {7'b0, mcu_int}, 8'h01);
        chk("R11 cmd byte", mcu_rdata, 8'h22);
        mcu_read();

        // R11 reply collision
        mcu_write(8'h33);
        @(posedge clk); #1;
        host_addr = 8'h60; host_rd = 1; mcu_wdata = 8'h44; mcu_wr = 1;
        to_host_q.push_back(8'h44);
        strobe_end();
        @(negedge clk);
        chk("R11 reply full", {7'b0, host_irq}, 8'h01);
        host_read_data();
        @(negedge clk);
        chk("R11 reply drained", {7'b0, host_irq}, 8'h00);
        chk("R2/R4 queues empty", 8'(to_host_q.size() + to_mcu_q.size()), 8'h00);

        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule